// File: doc/BRIEF.md
# DSP External Memory Page Mapper

This block sits between a 16-bit DSP address bus and the on-card memories. For every access it takes the DSP address and a space select (program, data or global) and forms a wide physical word address and one chip enable. The lower half of the program and data spaces always reaches page 0. That page holds the resident operating system and cannot be paged out. The upper half of each space reaches a page that the DSP picks by writing a configuration register. Program and data keep separate page selects. Global space opens a 32K-byte window into the flash, and the window position is held in a second register.

The configuration register also picks the SRAM organisation. In unified mode one 16-bit SRAM holds both program and data. In split mode a program SRAM and a data SRAM each hold two 32K-word pages. A page beyond the populated memory, or beyond the 96-page (3M-word) paged limit, enables nothing. Such an access raises an out-of-range pulse one cycle later. The address path and the chip enables are combinational. Only the two configuration registers and the out-of-range flag are clocked. No stream passes through the block, so all of its pins are plain control and address signals and there is no valid/ready handshake.

Top module: `dsp_page_mapper`

## Requirements
- R1: After reset, both page selects hold page 1, the mode is unified and the flash window is 0. A data access to 0x8000 therefore enables the unified SRAM with physical address 0x08000.
- R2: A program or data address in 0x0000–0x7FFF maps to page 0, whatever the page selects hold. The physical address then equals the DSP address.
- R3: A program or data address in 0x8000–0xFFFF maps to physical address {page, addr[14:0]}. The page comes from the program select for program space (0) and from the data select for data space (1).
- R4: A write to I/O address 0x54 loads the program page from bits [6:0], the data page from bits [13:7] and split mode from bit 14 (1 = split). The new values apply from the next cycle. A write to any other address, apart from R9's, changes nothing.
- R5: In unified mode, a program or data access whose page is below 4 asserts only the unified SRAM enable.
- R6: In split mode, a program access whose page is below 2 asserts only the program SRAM enable. A data access whose page is below 2 asserts only the data SRAM enable.
- R7: A program or data access whose page is 96 or more asserts no chip enable.
- R8: A global access (space 2) with addr[15]=0 asserts only the flash enable, at physical address {window, addr[14:0]}. With addr[15]=1 it asserts no enable.
- R9: A write to I/O address 0x55 loads the flash window from bits [1:0], effective from the next cycle.
- R10: out_of_range is high for exactly the one cycle that follows a strobed access which enabled no device. Space 3 is reserved, enables nothing and drives physical address 0.
- R11: With acc_strobe low, every chip enable is low, and out_of_range is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | DSP I/O write strobe |
| cfg_wr_addr | input | 8 | DSP I/O write address |
| cfg_wr_data | input | 15 | DSP I/O write data |
| acc_strobe | input | 1 | Memory access in progress this cycle |
| acc_space | input | 2 | 0 program, 1 data, 2 global, 3 reserved |
| acc_addr | input | 16 | DSP address |
| phys_addr | output | 22 | Physical address, {page, offset} or {window, offset} |
| ram_uni_ce | output | 1 | Unified 16-bit SRAM enable |
| ram_prog_ce | output | 1 | Split-mode program SRAM enable |
| ram_data_ce | output | 1 | Split-mode data SRAM enable |
| flash_ce | output | 1 | Flash enable |
| out_of_range | output | 1 | Pulse for an access that reached no memory |

## Verification
The chip enables and the physical address follow the access inputs in the same cycle. The bench drives each access just after a falling edge and compares these outputs 1 ns later, before the next rising edge. Register writes act from the next cycle, so the bench updates its own model of the registers only after it has checked the cycle that carried the write. out_of_range comes one rising edge after its access. The driver queues one expected flag per cycle, and a monitor takes each flag off the queue 2 ns after the following rising edge.

// File: rtl/dsp_map_pkg.sv
package dsp_map_pkg;
  localparam int PG_W   = 7;               // page select width (up to 128 pages)
  localparam int OFF_W  = 15;              // 32K words per page
  localparam int FW_W   = 2;               // flash window select (4 x 32K bytes)
  localparam int PA_W   = PG_W + OFF_W;    // physical address width
  localparam int CFG_DW = 2 * PG_W + 1;    // configuration write width
  localparam int A_W    = OFF_W + 1;       // DSP address width
  localparam int N_CE   = 4;

  localparam int CE_UNI   = 0;
  localparam int CE_PROG  = 1;
  localparam int CE_DATA  = 2;
  localparam int CE_FLASH = 3;

  typedef enum logic [1:0] {
    SPC_PROG   = 2'd0,
    SPC_DATA   = 2'd1,
    SPC_GLOBAL = 2'd2,
    SPC_RSVD   = 2'd3
  } space_e;

  typedef struct packed {
    logic            split;
    logic [PG_W-1:0] data_pg;
    logic [PG_W-1:0] prog_pg;
    logic [FW_W-1:0] win;
  } map_cfg_t;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/map_cfg_reg.sv
module map_cfg_reg
  import dsp_map_pkg::*;
#(
  parameter int              IO_W     = 8,
  parameter logic [IO_W-1:0] CFG_ADDR = 8'h54,
  parameter logic [IO_W-1:0] WIN_ADDR = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IO_W-1:0]   wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  output map_cfg_t          cfg
);
  localparam logic [PG_W-1:0] RST_PAGE = PG_W'(1);

  logic hit_cfg, hit_win;
  assign hit_cfg = wr_en && (wr_addr == CFG_ADDR);
  assign hit_win = wr_en && (wr_addr == WIN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.prog_pg <= RST_PAGE;
      cfg.data_pg <= RST_PAGE;
      cfg.split   <= 1'b0;
      cfg.win     <= '0;
    end else begin
      if (hit_cfg) begin
        cfg.prog_pg <= wr_data[PG_W-1:0];
        cfg.data_pg <= wr_data[2*PG_W-1:PG_W];
        cfg.split   <= wr_data[2*PG_W];
      end
      if (hit_win) begin
        cfg.win <= wr_data[FW_W-1:0];
      end
    end
  end

  // R4
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CFG_ADDR && wr_addr != WIN_ADDR) |=> $stable(cfg));

  // R9
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WIN_ADDR) |=> (cfg.win == $past(wr_data[FW_W-1:0])));
endmodule

// File: rtl/map_page_decode.sv
module map_page_decode
  import dsp_map_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  space_e          space,
  input  logic [A_W-1:0]  addr,
  input  map_cfg_t        cfg,
  output logic [PG_W-1:0] page,
  output logic [PA_W-1:0] phys
);
  localparam int GPAD = PA_W - FW_W - OFF_W;

  logic upper;
  assign upper = addr[OFF_W];

  always_comb begin
    page = '0;
    if (upper) begin
      case (space)
        SPC_PROG: page = cfg.prog_pg;
        SPC_DATA: page = cfg.data_pg;
        default:  page = '0;
      endcase
    end
  end

  always_comb begin
    case (space)
      SPC_PROG, SPC_DATA: phys = {page, addr[OFF_W-1:0]};
      SPC_GLOBAL:         phys = {{GPAD{1'b0}}, cfg.win, addr[OFF_W-1:0]};
      default:            phys = '0;
    endcase
  end

  // R2
  low_half_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((space == SPC_PROG || space == SPC_DATA) && !addr[OFF_W])
      |-> (phys == PA_W'(addr)));
endmodule

// File: rtl/map_bank_select.sv
module map_bank_select
  import dsp_map_pkg::*;
#(
  parameter int MAX_PAGES   = 96,
  parameter int UNI_PAGES   = 4,
  parameter int SPLIT_PAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  space_e          space,
  input  logic            addr_hi,
  input  logic [PG_W-1:0] page,
  input  logic            split,
  output logic [N_CE-1:0] ce
);
  localparam int UNI_LIM   = imin(UNI_PAGES, MAX_PAGES);
  localparam int SPLIT_LIM = imin(SPLIT_PAGES, MAX_PAGES);

  logic uni_ok, split_ok;
  assign uni_ok   = int'(page) < UNI_LIM;
  assign split_ok = int'(page) < SPLIT_LIM;

  always_comb begin
    ce = '0;
    if (strobe) begin
      case (space)
        SPC_PROG: begin
          if (split) ce[CE_PROG] = split_ok;
          else       ce[CE_UNI]  = uni_ok;
        end
        SPC_DATA: begin
          if (split) ce[CE_DATA] = split_ok;
          else       ce[CE_UNI]  = uni_ok;
        end
        SPC_GLOBAL: ce[CE_FLASH] = !addr_hi;
        default:    ce = '0;
      endcase
    end
  end

  // R5
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce));

  // R7
  page_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (space == SPC_PROG || space == SPC_DATA) && int'(page) >= MAX_PAGES)
      |-> (ce == '0));

  // R6
  split_unified_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split |-> !ce[CE_UNI]);

  // R11
  idle_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (ce == '0));
endmodule

// File: rtl/dsp_page_mapper.sv
module dsp_page_mapper
  import dsp_map_pkg::*;
#(
  parameter int              IO_W        = 8,
  parameter logic [IO_W-1:0] CFG_ADDR    = 8'h54,
  parameter logic [IO_W-1:0] WIN_ADDR    = 8'h55,
  parameter int              MAX_PAGES   = 96,
  parameter int              UNI_PAGES   = 4,
  parameter int              SPLIT_PAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IO_W-1:0]   cfg_wr_addr,
  input  logic [CFG_DW-1:0] cfg_wr_data,
  input  logic              acc_strobe,
  input  logic [1:0]        acc_space,
  input  logic [A_W-1:0]    acc_addr,
  output logic [PA_W-1:0]   phys_addr,
  output logic              ram_uni_ce,
  output logic              ram_prog_ce,
  output logic              ram_data_ce,
  output logic              flash_ce,
  output logic              out_of_range
);
  map_cfg_t        cfg;
  space_e          space;
  logic [PG_W-1:0] page;
  logic [N_CE-1:0] ce;

  assign space = space_e'(acc_space);

  map_cfg_reg #(.IO_W(IO_W), .CFG_ADDR(CFG_ADDR), .WIN_ADDR(WIN_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .cfg(cfg)
  );

  map_page_decode u_dec (
    .clk(clk), .rst_n(rst_n), .space(space), .addr(acc_addr), .cfg(cfg),
    .page(page), .phys(phys_addr)
  );

  map_bank_select #(
    .MAX_PAGES(MAX_PAGES), .UNI_PAGES(UNI_PAGES), .SPLIT_PAGES(SPLIT_PAGES)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .strobe(acc_strobe), .space(space),
    .addr_hi(acc_addr[OFF_W]), .page(page), .split(cfg.split), .ce(ce)
  );

  assign ram_uni_ce  = ce[CE_UNI];
  assign ram_prog_ce = ce[CE_PROG];
  assign ram_data_ce = ce[CE_DATA];
  assign flash_ce    = ce[CE_FLASH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_of_range <= 1'b0;
    else        out_of_range <= acc_strobe && (ce == '0);
  end

  // R10
  oor_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !ram_uni_ce && !ram_prog_ce && !ram_data_ce && !flash_ce)
      |=> out_of_range);

  // R10
  oor_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> $past(acc_strobe));

  // R11
  oor_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_strobe |=> !out_of_range);
endmodule

// File: tb/tb_dsp_page_mapper.sv
module tb_dsp_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [14:0] cfg_wr_data = '0;
  logic        acc_strobe = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [15:0] acc_addr = '0;
  logic [21:0] phys_addr;
  logic        ram_uni_ce, ram_prog_ce, ram_data_ce, flash_ce, out_of_range;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the register fields, from R1/R4/R9
  logic [6:0] m_prog  = 7'd1;
  logic [6:0] m_data  = 7'd1;
  logic       m_split = 1'b0;
  logic [1:0] m_win   = 2'd0;

  bit    exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  dsp_page_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .acc_strobe(acc_strobe), .acc_space(acc_space),
    .acc_addr(acc_addr), .phys_addr(phys_addr), .ram_uni_ce(ram_uni_ce),
    .ram_prog_ce(ram_prog_ce), .ram_data_ce(ram_data_ce), .flash_ce(flash_ce),
    .out_of_range(out_of_range)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected enables {flash, data, prog, uni} and address
  task automatic model(input bit stb, input logic [1:0] sp, input logic [15:0] a,
                       output logic [3:0] ce, output logic [21:0] pa);
    logic [6:0] pg;
    ce = 4'b0;
    pg = 7'd0;
    if (a[15]) pg = (sp == 2'd0) ? m_prog : (sp == 2'd1) ? m_data : 7'd0;
    case (sp)
      2'd0, 2'd1: pa = {pg, a[14:0]};
      2'd2:       pa = {5'd0, m_win, a[14:0]};
      default:    pa = '0;
    endcase
    if (stb) begin
      if (sp < 2'd2 && pg < 7'd96) begin
        if (!m_split) ce[0] = (pg < 7'd4);
        else if (sp == 2'd0) ce[1] = (pg < 7'd2);
        else ce[2] = (pg < 7'd2);
      end else if (sp == 2'd2) begin
        ce[3] = !a[15];
      end
    end
  endtask

  task automatic drive(input bit stb, input logic [1:0] sp, input logic [15:0] a,
                       input bit wr, input logic [7:0] wa, input logic [14:0] wd,
                       input string req);
    logic [3:0]  ece;
    logic [21:0] epa;
    @(negedge clk);
    acc_strobe  = stb;
    acc_space   = sp;
    acc_addr    = a;
    cfg_wr_en   = wr;
    cfg_wr_addr = wa;
    cfg_wr_data = wd;
    #1;
    model(stb, sp, a, ece, epa);
    chk({req, " enables"}, {28'd0, flash_ce, ram_data_ce, ram_prog_ce, ram_uni_ce}, {28'd0, ece});
    if (stb) chk({req, " phys_addr"}, {10'd0, phys_addr}, {10'd0, epa});
    exp_q.push_back(stb && (ece == 4'b0));
    req_q.push_back({req, " out_of_range"});
    if (wr && wa == 8'h54) begin
      m_prog  = wd[6:0];
      m_data  = wd[13:7];
      m_split = wd[14];
    end
    if (wr && wa == 8'h55) m_win = wd[1:0];
  endtask

  task automatic acc(input logic [1:0] sp, input logic [15:0] a, input string req);
    drive(1'b1, sp, a, 1'b0, 8'h00, 15'h0, req);
  endtask

  task automatic wr(input logic [7:0] wa, input logic [14:0] wd, input string req);
    drive(1'b0, 2'd0, 16'h0, 1'b1, wa, wd, req);
  endtask

  // monitor: out_of_range is due one rising edge after the access
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, {31'd0, out_of_range}, {31'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #12;
    // R11 and R1: reset state, nothing enabled
    chk("R11 reset enables", {28'd0, flash_ce, ram_data_ce, ram_prog_ce, ram_uni_ce}, 32'd0);
    chk("R1 reset out_of_range", {31'd0, out_of_range}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 15'h0, "R11 idle");
    acc(2'd1, 16'h8000, "R1 data upper default page");
    acc(2'd0, 16'h8123, "R1 prog upper default page");
    acc(2'd0, 16'h1234, "R2 prog low half");
    acc(2'd1, 16'h7FFF, "R2 data low half top");
    wr(8'h54, 15'h0103, "R4 write pages prog3 data2");
    acc(2'd0, 16'h8005, "R3 prog page 3");
    acc(2'd1, 16'h8005, "R3 data page 2");
    acc(2'd1, 16'h0005, "R2 data low half ignores select");
    wr(8'h53, 15'h7FFF, "R4 foreign address write");
    acc(2'd0, 16'h8005, "R4 prog page unchanged");
    acc(2'd1, 16'hFFFF, "R4 data page unchanged");
    wr(8'h54, 15'h0105, "R4 prog page 5");
    acc(2'd0, 16'h8000, "R5 unified page 5 unpopulated");
    acc(2'd0, 16'h8001, "R10 back-to-back miss");
    acc(2'd1, 16'h8000, "R10 hit after miss");
    acc(2'd0, 16'h0100, "R2 low half with bad select");
    wr(8'h54, 15'h0164, "R4 prog page 100");
    acc(2'd0, 16'hC000, "R7 page beyond paged limit");
    wr(8'h54, 15'h4081, "R4 split mode pages 1");
    acc(2'd0, 16'h8000, "R6 split prog page 1");
    acc(2'd1, 16'h9000, "R6 split data page 1");
    acc(2'd0, 16'h0010, "R6 split prog page 0");
    acc(2'd1, 16'h0020, "R6 split data page 0");
    wr(8'h54, 15'h4101, "R4 split data page 2");
    acc(2'd1, 16'h8000, "R6 split data page 2 unpopulated");
    acc(2'd0, 16'h8000, "R6 split prog still page 1");
    acc(2'd2, 16'h0042, "R8 flash window 0");
    wr(8'h55, 15'h0003, "R9 window 3");
    acc(2'd2, 16'h0042, "R9 flash window 3");
    acc(2'd2, 16'h7FFF, "R8 flash window top");
    acc(2'd2, 16'h8000, "R8 global upper half");
    acc(2'd3, 16'h1234, "R10 reserved space");
    wr(8'h54, 15'h0082, "R4 unified prog2 data1");
    acc(2'd0, 16'hFFFF, "R5 unified page 2");
    acc(2'd1, 16'h8000, "R5 unified data page 1");
    drive(1'b0, 2'd0, 16'h8000, 1'b0, 8'h0, 15'h0, "R11 idle after run");
    drive(1'b0, 2'd2, 16'h0000, 1'b0, 8'h0, 15'h0, "R11 idle global");
    repeat (3) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule